// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block records every destination-register rename made for one thread, so the rename stage can later either make the rename permanent or undo it. Each record holds four things: the instruction's sequence number, the architectural register, the physical register just handed out, and the physical register that the architectural register pointed to before. Records enter at the newest end of a circular buffer, one per renamed destination operand. A chip with several threads instantiates one buffer per thread.

When the commit stage reports a done sequence number, the block walks from the oldest end. It retires every record whose sequence number is not above the done number and returns each record's previous physical register to the free list. When a squash arrives, the block walks from the newest end instead. For every record younger than the squash number it writes the old mapping back into the rename map and returns the newly assigned register to the free list. If that register lies in the miscellaneous range, it also marks the register ready in the scoreboard. A flush undoes every record in the same newest-first order.

Both walks handle one record per clock and raise a busy flag while they run. Separate counters report how many records were undone and how many were retired. The rename map, free list and scoreboard storage sit outside this block and are driven through plain write strobes.

Top module: `rename_hist_buf`

## Requirements
- R1: A record is stored at the newest end in the cycle where `push_valid_i` and `push_ready_o` are both high. `push_ready_o` is low while DEPTH records are held or while a rollback walk runs. A push offered while `push_ready_o` is low is dropped.
- R2: Starting the cycle after a squash is accepted, one record per cycle is popped from the newest end while its sequence number is greater than the squash number (unsigned compare). Each pop raises `map_we_o` with the record's architectural register and previous physical register, and raises `free_valid_o` with the new physical register.
- R3: During a rollback pop whose new physical register is at or above NUM_INT_PHYS+NUM_FP_PHYS (96 by default), `sb_set_o` is high and `sb_phys_o` carries that register. Otherwise `sb_set_o` stays low.
- R4: Starting the cycle after a commit is accepted, records are popped from the oldest end, one per cycle and in age order, while their sequence number is less than or equal to the done number. Each pop raises `free_valid_o` with the previous physical register and leaves `map_we_o` low.
- R5: A commit is ignored when the buffer is empty or its oldest record has a sequence number above the done number: `busy_o` stays low and nothing is freed.
- R6: A commit offered in the same cycle as a squash or flush, or while a rollback walk runs, is ignored. No retire pop happens in a cycle that carries a squash or flush.
- R7: A squash offered while the buffer is empty does nothing: `busy_o` stays low and no strobe is raised.
- R8: `flush_i` undoes every held record, newest first, with the same outputs as R2 and R3, regardless of sequence numbers.
- R9: `busy_o` is high from the cycle after a walk is accepted until one cycle after its last pop. In that final busy cycle no strobe is raised. Every strobe appears only while `busy_o` is high.
- R10: `undone_cnt_o` increments once per rollback pop and `commit_cnt_o` once per retire pop. Both wrap at 2^CNT_W.
- R11: After reset the buffer is empty, no walk runs, `push_ready_o` is high, all strobes are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Offer a new rename record |
| push_ready_o | output | 1 | Record can be accepted this cycle |
| push_seq_i | input | SEQ_W | Sequence number of the renaming instruction |
| push_arch_i | input | ARCH_W | Architectural destination register |
| push_new_phys_i | input | PHYS_W | Physical register just assigned |
| push_prev_phys_i | input | PHYS_W | Physical register previously mapped |
| commit_valid_i | input | 1 | Done sequence number is valid |
| commit_seq_i | input | SEQ_W | Done sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Youngest surviving sequence number |
| flush_i | input | 1 | Undo every held record |
| map_we_o | output | 1 | Rename-map write strobe |
| map_arch_o | output | ARCH_W | Map entry to restore |
| map_phys_o | output | PHYS_W | Physical register written back to the map |
| free_valid_o | output | 1 | Free-list return strobe |
| free_phys_o | output | PHYS_W | Register returned to the free list |
| sb_set_o | output | 1 | Scoreboard ready-set strobe |
| sb_phys_o | output | PHYS_W | Register to mark ready |
| busy_o | output | 1 | A walk is running |
| undone_cnt_o | output | CNT_W | Rollback pops so far |
| commit_cnt_o | output | CNT_W | Retire pops so far |

## Verification
A commit, squash or flush sampled at a clock edge yields its first pop strobes in the cycle that follows that edge. Each later pop comes one cycle after the previous one, and `busy_o` drops one cycle after the last pop. The bench drives every request for exactly one edge, clears it just after that edge, and samples on the falling edge. Each sample therefore shows the pop chosen by the state after that edge, and one sample is taken per record walked. The counters move at the edge that ends each pop cycle, so they are read only after the walk has gone idle.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_UNDO   = 2'd1,
    MODE_RETIRE = 2'd2
  } rhb_mode_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_old_i,
  input  logic         pop_new_i,
  output logic [W-1:0] oldest_o,
  output logic [W-1:0] newest_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign oldest_o = mem_q[head_q];
  assign newest_o = mem_q[ptr_prev(tail_q)];
  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[tail_q] <= push_data_i;
  end

  // push and newest-end pop are exclusive (ready is low during rollback)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i)         tail_q <= ptr_next(tail_q);
      else if (pop_new_i) tail_q <= ptr_prev(tail_q);
      if (pop_old_i)      head_q <= ptr_next(head_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_old_i) - CNT_W'(pop_new_i);
    end
  end
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             squash_i,
  input  logic             flush_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             push_fire_i,
  input  logic             empty_i,
  input  logic [SEQ_W-1:0] oldest_seq_i,
  input  logic [SEQ_W-1:0] newest_seq_i,
  output logic             pop_old_o,
  output logic             pop_new_o,
  output rhb_mode_e        mode_o
);
  rhb_mode_e        mode_q;
  logic [SEQ_W-1:0] target_q;
  logic             flush_all_q;
  logic             any_sq, undo_hit, retire_hit, commit_ok;

  always_comb begin
    any_sq     = squash_i | flush_i;
    undo_hit   = (mode_q == MODE_UNDO) && !empty_i &&
                 (flush_all_q || (newest_seq_i > target_q));
    retire_hit = (mode_q == MODE_RETIRE) && !empty_i && (oldest_seq_i <= target_q);
    commit_ok  = commit_i && !empty_i && (oldest_seq_i <= commit_seq_i);
    pop_new_o  = undo_hit;
    // a squash cycle carries no retirement
    pop_old_o  = retire_hit && !any_sq;
  end

  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_IDLE;
      target_q    <= '0;
      flush_all_q <= 1'b0;
    end else if (any_sq) begin
      target_q    <= squash_seq_i;
      flush_all_q <= flush_i;
      mode_q      <= (!empty_i || push_fire_i) ? MODE_UNDO : MODE_IDLE;
    end else if (mode_q == MODE_UNDO) begin
      if (!undo_hit) mode_q <= MODE_IDLE;
    end else if (commit_ok) begin
      target_q <= commit_seq_i;
      mode_q   <= MODE_RETIRE;
    end else if ((mode_q == MODE_RETIRE) && !retire_hit) begin
      mode_q <= MODE_IDLE;
    end
  end
endmodule

// File: rtl/rhb_evcnt.sv
module rhb_evcnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf
  import rhb_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int SEQ_W        = 16,
  parameter int ARCH_W       = 5,
  parameter int PHYS_W       = 7,
  parameter int NUM_INT_PHYS = 48,
  parameter int NUM_FP_PHYS  = 48,
  parameter int CNT_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  output logic              push_ready_o,
  input  logic [SEQ_W-1:0]  push_seq_i,
  input  logic [ARCH_W-1:0] push_arch_i,
  input  logic [PHYS_W-1:0] push_new_phys_i,
  input  logic [PHYS_W-1:0] push_prev_phys_i,
  input  logic              commit_valid_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_valid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  input  logic              flush_i,
  output logic              map_we_o,
  output logic [ARCH_W-1:0] map_arch_o,
  output logic [PHYS_W-1:0] map_phys_o,
  output logic              free_valid_o,
  output logic [PHYS_W-1:0] free_phys_o,
  output logic              sb_set_o,
  output logic [PHYS_W-1:0] sb_phys_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  undone_cnt_o,
  output logic [CNT_W-1:0]  commit_cnt_o
);
  localparam int ENT_W  = SEQ_W + ARCH_W + 2 * PHYS_W;
  localparam int PRV_LO = 0;
  localparam int NEW_LO = PHYS_W;
  localparam int ARC_LO = 2 * PHYS_W;
  localparam int SEQ_LO = 2 * PHYS_W + ARCH_W;
  localparam logic [PHYS_W-1:0] MISC_BASE = PHYS_W'(NUM_INT_PHYS + NUM_FP_PHYS);

  logic [ENT_W-1:0]  oldest_w, newest_w;
  logic              empty, full, pop_old, pop_new, push_fire;
  rhb_mode_e         mode;
  logic [PHYS_W-1:0] new_newest, prev_newest, prev_oldest;
  logic              unused_bits;

  assign push_ready_o = !full && (mode != MODE_UNDO);
  assign push_fire    = push_valid_i && push_ready_o;

  rhb_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_fire),
    .push_data_i ({push_seq_i, push_arch_i, push_new_phys_i, push_prev_phys_i}),
    .pop_old_i   (pop_old),
    .pop_new_i   (pop_new),
    .oldest_o    (oldest_w),
    .newest_o    (newest_w),
    .empty_o     (empty),
    .full_o      (full)
  );

  rhb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .squash_i     (squash_valid_i),
    .flush_i      (flush_i),
    .squash_seq_i (squash_seq_i),
    .commit_i     (commit_valid_i),
    .commit_seq_i (commit_seq_i),
    .push_fire_i  (push_fire),
    .empty_i      (empty),
    .oldest_seq_i (oldest_w[SEQ_LO +: SEQ_W]),
    .newest_seq_i (newest_w[SEQ_LO +: SEQ_W]),
    .pop_old_o    (pop_old),
    .pop_new_o    (pop_new),
    .mode_o       (mode)
  );

  assign new_newest  = newest_w[NEW_LO +: PHYS_W];
  assign prev_newest = newest_w[PRV_LO +: PHYS_W];
  assign prev_oldest = oldest_w[PRV_LO +: PHYS_W];
  assign unused_bits = ^oldest_w[ARC_LO +: (ARCH_W + PHYS_W)] ^ ^oldest_w[NEW_LO +: PHYS_W];

  assign map_we_o     = pop_new;
  assign map_arch_o   = newest_w[ARC_LO +: ARCH_W];
  assign map_phys_o   = prev_newest;
  assign free_valid_o = pop_new | pop_old;
  assign free_phys_o  = pop_new ? new_newest : prev_oldest;
  assign sb_set_o     = pop_new && (new_newest >= MISC_BASE);
  assign sb_phys_o    = new_newest;
  assign busy_o       = (mode != MODE_IDLE);

  rhb_evcnt #(.W(CNT_W)) u_undone_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (pop_new), .cnt_o (undone_cnt_o)
  );

  rhb_evcnt #(.W(CNT_W)) u_commit_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (pop_old), .cnt_o (commit_cnt_o)
  );
endmodule

// File: rtl/rhb_chk.sv
module rhb_chk #(
  parameter int PHYS_W    = 7,
  parameter int MISC_BASE = 96,
  parameter int CNT_W     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              squash_valid_i,
  input logic              flush_i,
  input logic              push_ready_o,
  input logic              map_we_o,
  input logic              free_valid_o,
  input logic              sb_set_o,
  input logic [PHYS_W-1:0] sb_phys_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  undone_cnt_o,
  input logic [CNT_W-1:0]  commit_cnt_o
);
  // R2
  undo_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_we_o |-> free_valid_o);

  // R3
  misc_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_set_o |-> (map_we_o && (int'(sb_phys_o) >= MISC_BASE)));

  // R1
  no_push_in_undo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_we_o |-> !push_ready_o);

  // R6
  no_retire_on_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_valid_i || flush_i) |-> (!free_valid_o || map_we_o));

  // R9
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_o |-> busy_o);

  // R10
  retire_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_valid_o && !map_we_o) |=> (commit_cnt_o == $past(commit_cnt_o) + CNT_W'(1)));

  // R10
  undo_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_we_o |=> (undone_cnt_o == $past(undone_cnt_o) + CNT_W'(1)));
endmodule

bind rename_hist_buf rhb_chk #(
  .PHYS_W    (PHYS_W),
  .MISC_BASE (NUM_INT_PHYS + NUM_FP_PHYS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .squash_valid_i (squash_valid_i),
  .flush_i        (flush_i),
  .push_ready_o   (push_ready_o),
  .map_we_o       (map_we_o),
  .free_valid_o   (free_valid_o),
  .sb_set_o       (sb_set_o),
  .sb_phys_o      (sb_phys_o),
  .busy_o         (busy_o),
  .undone_cnt_o   (undone_cnt_o),
  .commit_cnt_o   (commit_cnt_o)
);

// File: tb/rename_hist_buf_tb.sv
module rename_hist_buf_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        push_valid, push_ready;
  logic [15:0] push_seq;
  logic [4:0]  push_arch;
  logic [6:0]  push_new, push_prev;
  logic        commit_valid, squash_valid, flush;
  logic [15:0] commit_seq, squash_seq;
  logic        map_we, free_valid, sb_set, busy;
  logic [4:0]  map_arch;
  logic [6:0]  map_phys, free_phys, sb_phys;
  logic [15:0] undone_cnt, commit_cnt;

  int checks = 0;
  int errors = 0;

  rename_hist_buf u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .push_valid_i (push_valid), .push_ready_o (push_ready),
    .push_seq_i (push_seq), .push_arch_i (push_arch),
    .push_new_phys_i (push_new), .push_prev_phys_i (push_prev),
    .commit_valid_i (commit_valid), .commit_seq_i (commit_seq),
    .squash_valid_i (squash_valid), .squash_seq_i (squash_seq),
    .flush_i (flush),
    .map_we_o (map_we), .map_arch_o (map_arch), .map_phys_o (map_phys),
    .free_valid_o (free_valid), .free_phys_o (free_phys),
    .sb_set_o (sb_set), .sb_phys_o (sb_phys), .busy_o (busy),
    .undone_cnt_o (undone_cnt), .commit_cnt_o (commit_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // op: 0 idle, 1 push, 2 commit, 3 squash
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] seq;
    logic [4:0]  arch;
    logic [6:0]  newp;
    logic [6:0]  prevp;
    logic        fv;
    logic [6:0]  fphys;
    logic        mwe;
    logic [6:0]  mphys;
    logic        sb;
    logic        bsy;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 16'd10, 5'd1, 7'd40,  7'd1, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b0},
    '{2'd1, 16'd11, 5'd2, 7'd41,  7'd2, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b0},
    '{2'd1, 16'd12, 5'd3, 7'd100, 7'd3, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b0},
    '{2'd1, 16'd13, 5'd4, 7'd42,  7'd4, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b0},
    '{2'd2, 16'd10, 5'd0, 7'd0,   7'd0, 1'b1, 7'd1,   1'b0, 7'd0, 1'b0, 1'b1},
    '{2'd0, 16'd0,  5'd0, 7'd0,   7'd0, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b1},
    '{2'd0, 16'd0,  5'd0, 7'd0,   7'd0, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b0},
    '{2'd3, 16'd11, 5'd0, 7'd0,   7'd0, 1'b1, 7'd42,  1'b1, 7'd4, 1'b0, 1'b1},
    '{2'd0, 16'd0,  5'd0, 7'd0,   7'd0, 1'b1, 7'd100, 1'b1, 7'd3, 1'b1, 1'b1},
    '{2'd0, 16'd0,  5'd0, 7'd0,   7'd0, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b1},
    '{2'd0, 16'd0,  5'd0, 7'd0,   7'd0, 1'b0, 7'd0,   1'b0, 7'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    push_valid = 1'b0; commit_valid = 1'b0; squash_valid = 1'b0; flush = 1'b0;
  endtask

  // inputs set before the call are seen at one edge only; returns at the falling edge
  task automatic step();
    @(posedge clk);
    #1;
    clear_inputs();
    @(negedge clk);
  endtask

  task automatic do_push(input int s, input int a, input int n, input int p);
    push_valid = 1'b1; push_seq = 16'(s); push_arch = 5'(a);
    push_new = 7'(n); push_prev = 7'(p);
    step();
  endtask

  task automatic do_commit(input int s);
    commit_valid = 1'b1; commit_seq = 16'(s);
    step();
  endtask

  task automatic do_squash(input int s);
    squash_valid = 1'b1; squash_seq = 16'(s);
    step();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    clear_inputs();
    push_seq = '0; push_arch = '0; push_new = '0; push_prev = '0;
    commit_seq = '0; squash_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 push_ready", int'(push_ready), 1);
    chk("R11 busy", int'(busy), 0);
    chk("R11 free_valid", int'(free_valid), 0);
    chk("R11 map_we", int'(map_we), 0);
    chk("R11 counters", int'(undone_cnt) + int'(commit_cnt), 0);

    // table: R1 pushes, R4 retire, R2/R3 rollback, R9 busy
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        2'd1: begin
          push_valid = 1'b1; push_seq = VECS[i].seq; push_arch = VECS[i].arch;
          push_new = VECS[i].newp; push_prev = VECS[i].prevp;
        end
        2'd2: begin commit_valid = 1'b1; commit_seq = VECS[i].seq; end
        2'd3: begin squash_valid = 1'b1; squash_seq = VECS[i].seq; end
        default: ;
      endcase
      step();
      chk($sformatf("R2 R4 vec%0d free_valid", i), int'(free_valid), int'(VECS[i].fv));
      if (VECS[i].fv)
        chk($sformatf("R2 R4 vec%0d free_phys", i), int'(free_phys), int'(VECS[i].fphys));
      chk($sformatf("R2 vec%0d map_we", i), int'(map_we), int'(VECS[i].mwe));
      if (VECS[i].mwe)
        chk($sformatf("R2 vec%0d map_phys", i), int'(map_phys), int'(VECS[i].mphys));
      chk($sformatf("R3 vec%0d sb_set", i), int'(sb_set), int'(VECS[i].sb));
      chk($sformatf("R9 vec%0d busy", i), int'(busy), int'(VECS[i].bsy));
    end
    chk("R2 map_arch after table", int'(map_arch), 2);
    chk("R10 undone after table", int'(undone_cnt), 2);
    chk("R10 committed after table", int'(commit_cnt), 1);

    // R5 commit older than the oldest record (seq 11)
    do_commit(5);
    chk("R5 busy stays low", int'(busy), 0);
    chk("R5 no free", int'(free_valid), 0);

    // R6 commit and squash in one cycle
    do_push(20, 5, 43, 5);
    do_push(21, 6, 44, 6);
    commit_valid = 1'b1; commit_seq = 16'd30;
    do_squash(20);
    chk("R6 rollback pop wins", int'(map_we), 1);
    chk("R2 free new phys", int'(free_phys), 44);
    chk("R2 map arch", int'(map_arch), 6);
    chk("R2 map phys", int'(map_phys), 6);
    chk("R1 ready low in rollback", int'(push_ready), 0);
    step();
    chk("R2 stop at squash seq", int'(free_valid), 0);
    chk("R9 tail busy", int'(busy), 1);
    step();
    chk("R9 idle", int'(busy), 0);
    do_commit(11);
    chk("R6 seq11 survived", int'(free_valid) * 1000 + int'(free_phys), 1002);
    chk("R4 no map write", int'(map_we), 0);
    step();
    chk("R4 stop at done seq", int'(free_valid), 0);
    step();
    chk("R9 idle after retire", int'(busy), 0);

    // R8 flush, with a commit offered mid-rollback (R6)
    do_push(22, 7, 101, 7);
    flush = 1'b1;
    step();
    chk("R8 first undo phys", int'(free_phys), 101);
    chk("R3 misc ready", int'(sb_set) * 1000 + int'(sb_phys), 1101);
    chk("R8 map phys", int'(map_phys), 7);
    commit_valid = 1'b1; commit_seq = 16'd100;
    step();
    chk("R8 second undo map", int'(map_we) * 1000 + int'(map_phys), 1005);
    chk("R6 commit ignored in rollback", int'(free_phys), 43);
    chk("R3 non-misc no ready", int'(sb_set), 0);
    step();
    chk("R8 empty after flush", int'(free_valid), 0);
    step();
    chk("R9 idle after flush", int'(busy), 0);
    chk("R10 undone", int'(undone_cnt), 5);
    chk("R10 committed", int'(commit_cnt), 2);

    // R7 squash on empty, R5 commit on empty
    do_squash(0);
    chk("R7 squash empty", int'(busy) + int'(free_valid) + int'(map_we), 0);
    do_commit(100);
    chk("R5 commit empty", int'(busy) + int'(free_valid), 0);

    // R1 full buffer
    for (int i = 0; i < 8; i++) do_push(30 + i, i, 50 + i, 10 + i);
    chk("R1 ready low when full", int'(push_ready), 0);
    do_push(99, 9, 60, 20);
    do_commit(1000);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R4 retire order %0d", i), int'(free_valid) * 1000 + int'(free_phys),
          1010 + i);
      step();
    end
    chk("R1 dropped push absent", int'(free_valid), 0);
    step();
    chk("R9 idle after drain", int'(busy), 0);
    chk("R10 committed final", int'(commit_cnt), 10);
    chk("R1 ready after drain", int'(push_ready), 1);

    finish_run();
  end
endmodule